// File: doc/BRIEF.md
# Scatter-Gather Descriptor Dispatcher

This block sits at the front of a scatter-gather DMA engine. Software builds each transfer descriptor by writing eight 32-bit words into a staging window. Seven of those words only load holding registers. The eighth word, the control word, decides whether the descriptor moves on. When that word carries the go bit, the whole eight-word descriptor enters a descriptor FIFO as one entry. The dispatcher offers the oldest entry to a downstream mover over a valid/ready handshake. It keeps at most one descriptor outstanding, and it waits for the mover's completion before it offers the next one.

A small register file lets software control and observe the block. Through it, software can halt issuing, halt on a completion that reports an error or an early end, enable an interrupt, and run a timed soft reset that flushes all queued state. The same registers report the fill levels, the sequence numbers of the descriptors most recently issued and completed, and a set of status bits. The sticky status bits are cleared by writing 1 to them.

Top module: `sgdma_dispatch`

## Requirements
- R1: Writes to descriptor indexes 0 to 6 only load staging registers, and a write to index 7 with bit 31 clear commits nothing. Staged words persist, so a later commit uses the latest value written to each index.
- R2: A write to index 7 with bit 31 set commits one entry. When that entry is issued, word i of `issue_desc` (bits 32*i+31 down to 32*i) equals the last value written to index i, and word 7 equals the control word as written.
- R3: A commit made while the FIFO holds DEPTH entries is dropped. The fill level stays at DEPTH, and the entries already queued are issued unchanged.
- R4: Entries are issued in commit order, and at most one is outstanding. After a handshake, `issue_valid` stays low until `cmp_valid` is seen for that descriptor.
- R5: Register 2 reports the descriptor FIFO count in both bits 31:16 and bits 15:0. Status bit 1 reads 1 when the count is 0, and status bit 2 reads 1 when the count equals DEPTH.
- R6: Register 3 counts completions not yet popped. It increments on each completion, saturates at RESP_DEPTH and decrements on `resp_pop`. Status bit 3 reads 1 when this count is 0, and status bit 4 reads 1 when it equals RESP_DEPTH.
- R7: In register 4, bits 15:0 hold the sequence field (bits 15:0 of word 3) of the descriptor issued last. Bits 31:16 hold the sequence field of the descriptor completed last.
- R8: While control bit 0 or control bit 5 is set, nothing new is issued. Status bit 5 reads 1 when issuing is held and no descriptor is outstanding, and status bit 0 reads 1 while a descriptor is outstanding. Clearing the control bits resumes issuing.
- R9: A completion with a nonzero `cmp_error` while control bit 2 is set sets status bit 8-less error halt flag status bit 7. A completion with `cmp_early` while control bit 3 is set sets status bit 8. Either flag halts issuing until it is cleared.
- R10: Status bit 9 is set by a completion in three cases: the control word of the completed descriptor has bit 14 set; its bits 23:16 share a set bit with `cmp_error`; or `cmp_early` is high and its bit 15 is set. `irq` equals status bit 9 AND control bit 4.
- R11: Writing 1 to status bit 7, 8 or 9 clears that bit. Writing 0 leaves it unchanged, and writes to the other status bits have no effect.
- R12: Writing control bit 1 makes status bit 6 read 1 for RST_CYCLES cycles. During that time nothing is issued, and the FIFO, the response count, the sequence numbers and all sticky bits are cleared. After that, the control register reads 0.
- R13: After the `rst_n` reset, status reads 0x00A, the control register reads 0, `issue_valid` is 0 and `irq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dsc_wr_en | input | 1 | Descriptor word write strobe |
| dsc_wr_idx | input | 3 | Descriptor word index, 7 = control word |
| dsc_wr_data | input | 32 | Descriptor word data |
| csr_wr_en | input | 1 | Register write strobe |
| csr_addr | input | 3 | Register word index (0 status, 1 control, 2 fill, 3 response count, 4 sequence) |
| csr_wr_data | input | 32 | Register write data |
| csr_rd_data | output | 32 | Register read data, combinational from `csr_addr` |
| issue_valid | output | 1 | Descriptor offered to the mover |
| issue_ready | input | 1 | Mover accepts the offered descriptor |
| issue_desc | output | 256 | Offered descriptor, word i in bits 32*i+31:32*i |
| cmp_valid | input | 1 | Mover finished the outstanding descriptor |
| cmp_error | input | 8 | Error code reported with the completion |
| cmp_early | input | 1 | Completion ended early |
| resp_pop | input | 1 | One completion record consumed |
| irq | output | 1 | Interrupt request |

## Verification
The assertions take two things for granted about the inputs. The mover raises `cmp_valid` only while a descriptor is outstanding, and `resp_pop` is pulsed only when the response count is nonzero. The bench models the mover so that it completes a descriptor only after taking it through the handshake. It pops exactly as many completion records as it produced. Register writes are issued one at a time, and a reset command is never overlapped with a descriptor handshake that the bench still expects to see.

// File: rtl/sgd_pkg.sv
package sgd_pkg;
   localparam int unsigned WORD_W     = 32;
   localparam int unsigned DESC_WORDS = 8;
   localparam int unsigned DESC_W     = WORD_W * DESC_WORDS;
   localparam int unsigned IDX_W      = $clog2(DESC_WORDS);
   localparam int unsigned CTL_POS    = DESC_WORDS - 1;
   localparam int unsigned SEQ_POS    = 3;
   localparam int unsigned SEQ_W      = 16;
   localparam int unsigned ERR_W      = 8;

   // control word bit positions inside the descriptor
   localparam int unsigned CW_GO        = 31;
   localparam int unsigned CW_CMP_IRQ   = 14;
   localparam int unsigned CW_EARLY_IRQ = 15;
   localparam int unsigned CW_ERR_LO    = 16;

   typedef enum logic [2:0] {
      RG_STATUS  = 3'd0,
      RG_CONTROL = 3'd1,
      RG_FILL    = 3'd2,
      RG_RESP    = 3'd3,
      RG_SEQ     = 3'd4
   } reg_sel_e;

   // status bits
   localparam int unsigned ST_BUSY     = 0;
   localparam int unsigned ST_D_EMPTY  = 1;
   localparam int unsigned ST_D_FULL   = 2;
   localparam int unsigned ST_R_EMPTY  = 3;
   localparam int unsigned ST_R_FULL   = 4;
   localparam int unsigned ST_STOPPED  = 5;
   localparam int unsigned ST_RESETTING = 6;
   localparam int unsigned ST_HALT_ERR = 7;
   localparam int unsigned ST_HALT_ERLY = 8;
   localparam int unsigned ST_IRQ      = 9;
   localparam int unsigned ST_W        = 10;

   // control bits
   localparam int unsigned CT_STOP      = 0;
   localparam int unsigned CT_RESET     = 1;
   localparam int unsigned CT_HALT_ERR  = 2;
   localparam int unsigned CT_HALT_ERLY = 3;
   localparam int unsigned CT_IRQ_EN    = 4;
   localparam int unsigned CT_NO_FETCH  = 5;
   localparam int unsigned CT_W         = 6;
endpackage

// File: rtl/sgd_stage.sv
module sgd_stage
   import sgd_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [WORD_W-1:0] wr_data,
   output logic              commit,
   output logic [DESC_W-1:0] entry
);
   logic [WORD_W-1:0] held [CTL_POS];

   for (genvar g = 0; g < int'(CTL_POS); g++) begin : g_word
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            held[g] <= '0;
         end else if (wr_en && wr_idx == IDX_W'(g)) begin
            held[g] <= wr_data;
         end
      end
      assign entry[g*WORD_W +: WORD_W] = held[g];
   end

   // the control word travels straight from the bus into the entry
   assign entry[CTL_POS*WORD_W +: WORD_W] = wr_data;
   assign commit = wr_en && (wr_idx == IDX_W'(CTL_POS)) && wr_data[CW_GO];
endmodule

// File: rtl/sgd_fifo.sv
module sgd_fifo #(
   parameter int unsigned WIDTH = 256,
   parameter int unsigned DEPTH = 8,
   localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic             push,
   input  logic             pop,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] dout,
   output logic [CNT_W-1:0] count,
   output logic             full,
   output logic             empty,
   output logic             overflow
);
   if (DEPTH < 1) begin : g_bad_depth
      $error("sgd_fifo: DEPTH must be at least 1");
   end
   if (DEPTH > 1 && (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_pow2
      $error("sgd_fifo: DEPTH above 1 must be a power of two");
   end

   logic push_ok, pop_ok;
   logic [CNT_W-1:0] cnt;

   assign full    = (cnt == CNT_W'(DEPTH));
   assign empty   = (cnt == '0);
   assign push_ok = push && !full;
   assign pop_ok  = pop && !empty;
   assign count   = cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (flush) begin
         cnt <= '0;
      end else begin
         cnt <= cnt + CNT_W'(push_ok) - CNT_W'(pop_ok);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         overflow <= 1'b0;
      end else if (flush) begin
         overflow <= 1'b0;
      end else if (push && full) begin
         overflow <= 1'b1;
      end
   end

   if (DEPTH == 1) begin : g_single
      logic [WIDTH-1:0] slot;
      always_ff @(posedge clk) begin
         if (push_ok) slot <= din;
      end
      assign dout = slot;
   end else begin : g_ring
      localparam int unsigned PTR_W = $clog2(DEPTH);
      logic [WIDTH-1:0] mem [DEPTH];
      logic [PTR_W-1:0] wp, rp;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            wp <= '0;
            rp <= '0;
         end else if (flush) begin
            wp <= '0;
            rp <= '0;
         end else begin
            if (push_ok) wp <= wp + 1'b1;
            if (pop_ok)  rp <= rp + 1'b1;
         end
      end
      always_ff @(posedge clk) begin
         if (push_ok) mem[wp] <= din;
      end
      assign dout = mem[rp];
   end

   // R3: a commit into a full queue leaves it full and its head intact
   a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      (full && push && !pop && !flush) |=> (full && $stable(dout)));
   // R5: count never exceeds capacity
   a_r5_count_limit: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CNT_W'(DEPTH));
   // R3: the dropped-commit flag only rises after a push into a full queue
   a_r3_ovf_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(overflow) |-> $past(push && full));
endmodule

// File: rtl/sgd_csr.sv
module sgd_csr
   import sgd_pkg::*;
#(
   parameter int unsigned FIFO_CNT_W = 4,
   parameter int unsigned RESP_DEPTH = 8,
   parameter int unsigned RST_CYCLES = 4,
   localparam int unsigned RESP_W = $clog2(RESP_DEPTH + 1),
   localparam int unsigned RCNT_W = $clog2(RST_CYCLES + 1)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  csr_wr_en,
   input  logic [2:0]            csr_addr,
   input  logic [ST_W-1:0]       csr_wr_bits,
   output logic [WORD_W-1:0]     csr_rd_data,
   input  logic                  inflight,
   input  logic [FIFO_CNT_W-1:0] fifo_count,
   input  logic                  fifo_full,
   input  logic                  fifo_empty,
   input  logic                  issue_fire,
   input  logic [SEQ_W-1:0]      issue_seq,
   input  logic                  cmp_fire,
   input  logic [ERR_W-1:0]      cmp_error,
   input  logic                  cmp_early,
   input  logic                  cur_cmp_irq,
   input  logic                  cur_early_irq,
   input  logic [ERR_W-1:0]      cur_err_mask,
   input  logic                  resp_pop,
   output logic                  hold_issue,
   output logic                  resetting,
   output logic                  irq
);
   if (RST_CYCLES < 1) begin : g_bad_rst
      $error("sgd_csr: RST_CYCLES must be at least 1");
   end
   if (RESP_DEPTH < 1 || RESP_DEPTH > 65535) begin : g_bad_resp
      $error("sgd_csr: RESP_DEPTH out of range");
   end
   if (FIFO_CNT_W > 16) begin : g_bad_cnt
      $error("sgd_csr: fill count wider than its field");
   end

   logic [CT_W-1:0]   ctl;
   logic [RCNT_W-1:0] rst_cnt;
   logic              halt_err, halt_erly, irq_st;
   logic [RESP_W-1:0] resp_cnt;
   logic [SEQ_W-1:0]  seq_rd, seq_wr;
   logic              wr_status, wr_ctl, rst_cmd;
   logic              err_hit, erly_hit, irq_cause, held_by_sw;
   logic              resp_full, resp_empty;
   logic [ST_W-1:0]   status;

   assign resetting = (rst_cnt != '0);
   assign wr_status = csr_wr_en && csr_addr == RG_STATUS  && !resetting;
   assign wr_ctl    = csr_wr_en && csr_addr == RG_CONTROL && !resetting;
   assign rst_cmd   = wr_ctl && csr_wr_bits[CT_RESET];

   assign err_hit   = cmp_fire && (cmp_error != '0);
   assign erly_hit  = cmp_fire && cmp_early;
   assign irq_cause = cmp_fire && (cur_cmp_irq || ((cmp_error & cur_err_mask) != '0)
                                   || (cmp_early && cur_early_irq));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl     <= '0;
         rst_cnt <= '0;
      end else if (rst_cmd) begin
         ctl     <= csr_wr_bits[CT_W-1:0];
         rst_cnt <= RCNT_W'(RST_CYCLES);
      end else if (resetting) begin
         rst_cnt <= rst_cnt - 1'b1;
         if (rst_cnt == RCNT_W'(1)) ctl <= '0;
      end else if (wr_ctl) begin
         ctl <= csr_wr_bits[CT_W-1:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         halt_err  <= 1'b0;
         halt_erly <= 1'b0;
         irq_st    <= 1'b0;
      end else if (resetting) begin
         halt_err  <= 1'b0;
         halt_erly <= 1'b0;
         irq_st    <= 1'b0;
      end else begin
         halt_err  <= (halt_err  && !(wr_status && csr_wr_bits[ST_HALT_ERR]))
                      || (err_hit && ctl[CT_HALT_ERR]);
         halt_erly <= (halt_erly && !(wr_status && csr_wr_bits[ST_HALT_ERLY]))
                      || (erly_hit && ctl[CT_HALT_ERLY]);
         irq_st    <= (irq_st    && !(wr_status && csr_wr_bits[ST_IRQ])) || irq_cause;
      end
   end

   assign resp_full  = (resp_cnt == RESP_W'(RESP_DEPTH));
   assign resp_empty = (resp_cnt == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         resp_cnt <= '0;
      end else if (resetting) begin
         resp_cnt <= '0;
      end else begin
         resp_cnt <= resp_cnt + RESP_W'(cmp_fire && !resp_full)
                              - RESP_W'(resp_pop && !resp_empty);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seq_rd <= '0;
         seq_wr <= '0;
      end else if (resetting) begin
         seq_rd <= '0;
         seq_wr <= '0;
      end else begin
         if (issue_fire) seq_rd <= issue_seq;
         if (cmp_fire)   seq_wr <= seq_rd;
      end
   end

   assign held_by_sw = ctl[CT_STOP] || ctl[CT_NO_FETCH] || halt_err || halt_erly;
   assign hold_issue = held_by_sw || resetting;
   assign irq        = irq_st && ctl[CT_IRQ_EN];

   always_comb begin
      status               = '0;
      status[ST_BUSY]      = inflight;
      status[ST_D_EMPTY]   = fifo_empty;
      status[ST_D_FULL]    = fifo_full;
      status[ST_R_EMPTY]   = resp_empty;
      status[ST_R_FULL]    = resp_full;
      status[ST_STOPPED]   = held_by_sw && !inflight;
      status[ST_RESETTING] = resetting;
      status[ST_HALT_ERR]  = halt_err;
      status[ST_HALT_ERLY] = halt_erly;
      status[ST_IRQ]       = irq_st;
   end

   always_comb begin
      csr_rd_data = '0;
      case (csr_addr)
         RG_STATUS:  csr_rd_data = WORD_W'(status);
         RG_CONTROL: csr_rd_data = WORD_W'(ctl);
         RG_FILL:    csr_rd_data = {16'(fifo_count), 16'(fifo_count)};
         RG_RESP:    csr_rd_data = WORD_W'(resp_cnt);
         RG_SEQ:     csr_rd_data = {seq_wr, seq_rd};
         default:    csr_rd_data = '0;
      endcase
   end

   // R10: the interrupt flag only rises on a completion
   a_r10_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_st) |-> $past(cmp_fire));
   // R12: the control register reads zero once the reset phase ends
   a_r12_ctl_cleared: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(resetting) |-> (ctl == '0));
   // R6: input rule, a record is only consumed when one is held
   a_r6_pop_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
      resp_pop |-> !resp_empty);
   // R9: a halt flag rises only on a completion
   a_r9_halt_cause: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(halt_err) || $rose(halt_erly)) |-> $past(cmp_fire));
endmodule

// File: rtl/sgdma_dispatch.sv
module sgdma_dispatch
   import sgd_pkg::*;
#(
   parameter int unsigned DEPTH      = 8,
   parameter int unsigned RESP_DEPTH = 8,
   parameter int unsigned RST_CYCLES = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              dsc_wr_en,
   input  logic [2:0]        dsc_wr_idx,
   input  logic [31:0]       dsc_wr_data,
   input  logic              csr_wr_en,
   input  logic [2:0]        csr_addr,
   input  logic [31:0]       csr_wr_data,
   output logic [31:0]       csr_rd_data,
   output logic              issue_valid,
   input  logic              issue_ready,
   output logic [255:0]      issue_desc,
   input  logic              cmp_valid,
   input  logic [7:0]        cmp_error,
   input  logic              cmp_early,
   input  logic              resp_pop,
   output logic              irq
);
   localparam int unsigned CNT_W = $clog2(DEPTH + 1);

   if (DEPTH > 65535) begin : g_bad_depth
      $error("sgdma_dispatch: DEPTH exceeds the fill field");
   end

   logic              commit;
   logic [DESC_W-1:0] entry, head;
   logic [CNT_W-1:0]  fifo_count;
   logic              fifo_full, fifo_empty, fifo_ovf;
   logic              hold_issue, resetting;
   logic              issue_fire, cmp_fire, inflight;
   logic              cur_cmp_irq, cur_early_irq;
   logic [ERR_W-1:0]  cur_err_mask;
   logic [WORD_W-1:0] head_ctl;
   logic              unused_wr_bits;

   assign unused_wr_bits = ^csr_wr_data[31:ST_W];

   sgd_stage u_stage (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (dsc_wr_en),
      .wr_idx  (dsc_wr_idx),
      .wr_data (dsc_wr_data),
      .commit  (commit),
      .entry   (entry)
   );

   sgd_fifo #(.WIDTH(DESC_W), .DEPTH(DEPTH)) u_fifo (
      .clk      (clk),
      .rst_n    (rst_n),
      .flush    (resetting),
      .push     (commit),
      .pop      (issue_fire),
      .din      (entry),
      .dout     (head),
      .count    (fifo_count),
      .full     (fifo_full),
      .empty    (fifo_empty),
      .overflow (fifo_ovf)
   );

   assign head_ctl    = head[CTL_POS*WORD_W +: WORD_W];
   assign issue_valid = !fifo_empty && !inflight && !hold_issue;
   assign issue_fire  = issue_valid && issue_ready;
   assign issue_desc  = head;
   assign cmp_fire    = cmp_valid && inflight && !resetting;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         inflight      <= 1'b0;
         cur_cmp_irq   <= 1'b0;
         cur_early_irq <= 1'b0;
         cur_err_mask  <= '0;
      end else if (resetting) begin
         inflight <= 1'b0;
      end else if (issue_fire) begin
         inflight      <= 1'b1;
         cur_cmp_irq   <= head_ctl[CW_CMP_IRQ];
         cur_early_irq <= head_ctl[CW_EARLY_IRQ];
         cur_err_mask  <= head_ctl[CW_ERR_LO +: ERR_W];
      end else if (cmp_fire) begin
         inflight <= 1'b0;
      end
   end

   sgd_csr #(
      .FIFO_CNT_W (CNT_W),
      .RESP_DEPTH (RESP_DEPTH),
      .RST_CYCLES (RST_CYCLES)
   ) u_csr (
      .clk           (clk),
      .rst_n         (rst_n),
      .csr_wr_en     (csr_wr_en),
      .csr_addr      (csr_addr),
      .csr_wr_bits   (csr_wr_data[ST_W-1:0]),
      .csr_rd_data   (csr_rd_data),
      .inflight      (inflight),
      .fifo_count    (fifo_count),
      .fifo_full     (fifo_full),
      .fifo_empty    (fifo_empty),
      .issue_fire    (issue_fire),
      .issue_seq     (head[SEQ_POS*WORD_W +: SEQ_W]),
      .cmp_fire      (cmp_fire),
      .cmp_error     (cmp_error),
      .cmp_early     (cmp_early),
      .cur_cmp_irq   (cur_cmp_irq),
      .cur_early_irq (cur_early_irq),
      .cur_err_mask  (cur_err_mask),
      .resp_pop      (resp_pop),
      .hold_issue    (hold_issue),
      .resetting     (resetting),
      .irq           (irq)
   );

   // R4: after a handshake nothing further is offered the next cycle
   a_r4_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
      issue_fire |=> !issue_valid);
   // R4: input rule, completions only arrive for an outstanding descriptor
   a_r4_cmp_inflight: assert property (@(posedge clk) disable iff (!rst_n)
      cmp_valid |-> inflight);
   // R12: the reset phase empties the queue one cycle after it starts
   a_r12_flush: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(resetting) |=> fifo_empty);
   // R3: a dropped commit never disturbs the queue count
   a_r3_full_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_full && commit && !issue_fire && !resetting) |=> fifo_full);
   // R3: once set, the dropped-commit flag stays until a reset phase
   a_r3_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_ovf && !resetting) |=> fifo_ovf);
endmodule

// File: tb/sgdma_dispatch_bench.sv
module sgdma_dispatch_bench;
   localparam int DEPTH = 8;
   localparam int RESP_DEPTH = 8;
   localparam int RST_CYCLES = 4;
   localparam logic [31:0] GO = 32'h8000_0000;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         dsc_wr_en = 1'b0;
   logic [2:0]   dsc_wr_idx = '0;
   logic [31:0]  dsc_wr_data = '0;
   logic         csr_wr_en = 1'b0;
   logic [2:0]   csr_addr = '0;
   logic [31:0]  csr_wr_data = '0;
   logic [31:0]  csr_rd_data;
   logic         issue_valid;
   logic         issue_ready = 1'b0;
   logic [255:0] issue_desc;
   logic         cmp_valid = 1'b0;
   logic [7:0]   cmp_error = '0;
   logic         cmp_early = 1'b0;
   logic         resp_pop = 1'b0;
   logic         irq;

   int vectors = 0;
   int errors = 0;
   bit finished = 0;

   always #5 clk = ~clk;

   sgdma_dispatch #(.DEPTH(DEPTH), .RESP_DEPTH(RESP_DEPTH), .RST_CYCLES(RST_CYCLES))
   u_sgdma_dispatch (
      .clk(clk), .rst_n(rst_n),
      .dsc_wr_en(dsc_wr_en), .dsc_wr_idx(dsc_wr_idx), .dsc_wr_data(dsc_wr_data),
      .csr_wr_en(csr_wr_en), .csr_addr(csr_addr), .csr_wr_data(csr_wr_data),
      .csr_rd_data(csr_rd_data),
      .issue_valid(issue_valid), .issue_ready(issue_ready), .issue_desc(issue_desc),
      .cmp_valid(cmp_valid), .cmp_error(cmp_error), .cmp_early(cmp_early),
      .resp_pop(resp_pop), .irq(irq)
   );

   task automatic check32(input string tag, input logic [31:0] act, input logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [255:0] mk_desc(input logic [7:0] tag, input logic [15:0] seq,
                                            input logic [31:0] ctl);
      logic [255:0] d;
      for (int i = 0; i < 8; i++) d[i*32 +: 32] = {tag, 8'(i), 16'h3C00 + 16'(i)};
      d[3*32 +: 32] = {16'h0000, seq};
      d[7*32 +: 32] = ctl | GO;
      return d;
   endfunction

   task automatic dsc_write(input int idx, input logic [31:0] data);
      @(negedge clk);
      dsc_wr_en = 1'b1; dsc_wr_idx = 3'(idx); dsc_wr_data = data;
      @(negedge clk);
      dsc_wr_en = 1'b0;
   endtask

   task automatic push_desc(input logic [255:0] d, input bit go);
      for (int i = 0; i < 8; i++) begin
         @(negedge clk);
         dsc_wr_en = 1'b1;
         dsc_wr_idx = 3'(i);
         dsc_wr_data = d[i*32 +: 32];
         if (i == 7 && !go) dsc_wr_data[31] = 1'b0;
      end
      @(negedge clk);
      dsc_wr_en = 1'b0;
   endtask

   task automatic csr_wr(input int a, input logic [31:0] data);
      @(negedge clk);
      csr_wr_en = 1'b1; csr_addr = 3'(a); csr_wr_data = data;
      @(negedge clk);
      csr_wr_en = 1'b0;
   endtask

   task automatic csr_rd(input int a, output logic [31:0] v);
      csr_addr = 3'(a);
      #1;
      v = csr_rd_data;
   endtask

   task automatic take(input string tag, input logic [255:0] exp);
      int n = 0;
      @(negedge clk);
      while (!issue_valid && n < 200) begin
         @(negedge clk);
         n++;
      end
      check32({tag, " valid"}, 32'(issue_valid), 32'd1);
      vectors++;
      if (issue_desc !== exp) begin
         errors++;
         $display("FAIL %s desc actual=%h expected=%h", tag, issue_desc, exp);
      end
      issue_ready = 1'b1;
      @(negedge clk);
      issue_ready = 1'b0;
   endtask

   task automatic complete(input logic [7:0] e, input logic erly);
      @(negedge clk);
      cmp_valid = 1'b1; cmp_error = e; cmp_early = erly;
      @(negedge clk);
      cmp_valid = 1'b0; cmp_error = '0; cmp_early = 1'b0;
   endtask

   task automatic pop_n(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         resp_pop = 1'b1;
         @(negedge clk);
         resp_pop = 1'b0;
      end
   endtask

   task automatic t_reset_state;
      logic [31:0] v;
      @(negedge clk);
      csr_rd(0, v); check32("R13 status after reset", v, 32'h0000_000A);
      csr_rd(1, v); check32("R13 control after reset", v, 32'h0);
      check32("R13 valid after reset", 32'(issue_valid), 32'd0);
      check32("R13 irq after reset", 32'(irq), 32'd0);
   endtask

   task automatic t_staging;
      logic [31:0] v;
      logic [255:0] a, e;
      a = mk_desc(8'h11, 16'h0055, 32'h0);
      push_desc(a, 1'b0);
      csr_rd(2, v); check32("R1 no commit without go", v, 32'h0);
      check32("R1 nothing offered", 32'(issue_valid), 32'd0);
      dsc_write(2, 32'hDEAD_0002);
      dsc_write(7, GO | 32'h0000_0300);
      e = a;
      e[2*32 +: 32] = 32'hDEAD_0002;
      e[7*32 +: 32] = GO | 32'h0000_0300;
      csr_rd(2, v); check32("R5 fill after one commit", v, 32'h0001_0001);
      take("R2 staged words", e);
      complete(8'h0, 1'b0);
      pop_n(1);
   endtask

   task automatic t_order;
      logic [31:0] v;
      logic [255:0] d [3];
      csr_wr(1, 32'h20);
      for (int i = 0; i < 3; i++) begin
         d[i] = mk_desc(8'h20 + 8'(i), 16'(i + 1), 32'h0);
         push_desc(d[i], 1'b1);
      end
      csr_rd(2, v); check32("R5 fill three", v, 32'h0003_0003);
      csr_rd(0, v); check32("R8 stopped while fetch held", v & 32'h23, 32'h20);
      check32("R8 no issue while held", 32'(issue_valid), 32'd0);
      csr_wr(1, 32'h0);
      for (int i = 0; i < 3; i++) begin
         take("R4 commit order", d[i]);
         csr_rd(4, v); check32("R7 issued seq", v & 32'hFFFF, 32'(i + 1));
         csr_rd(0, v); check32("R8 busy while outstanding", v & 32'h21, 32'h1);
         repeat (3) begin
            @(negedge clk);
            check32("R4 held until completion", 32'(issue_valid), 32'd0);
         end
         complete(8'h0, 1'b0);
         csr_rd(4, v); check32("R7 completed seq", v >> 16, 32'(i + 1));
         csr_rd(3, v); check32("R6 response count", v, 32'(i + 1));
      end
      pop_n(3);
      csr_rd(3, v); check32("R6 count after pops", v, 32'h0);
      csr_rd(0, v); check32("R6 response empty bit", v & 32'h18, 32'h08);
   endtask

   task automatic t_overflow;
      logic [31:0] v;
      csr_wr(1, 32'h01);
      for (int i = 0; i <= DEPTH; i++) push_desc(mk_desc(8'h40, 16'(16 + i), 32'h0), 1'b1);
      csr_rd(2, v); check32("R3 fill stays at depth", v, {16'(DEPTH), 16'(DEPTH)});
      csr_rd(0, v); check32("R5 full bit", v & 32'h6, 32'h4);
      csr_wr(1, 32'h0);
      for (int i = 0; i < DEPTH; i++) begin
         take("R3 queued entries intact", mk_desc(8'h40, 16'(16 + i), 32'h0));
         complete(8'h0, 1'b0);
      end
      repeat (4) begin
         @(negedge clk);
         check32("R3 dropped entry never issued", 32'(issue_valid), 32'd0);
      end
      csr_rd(3, v); check32("R6 response count full", v, 32'(RESP_DEPTH));
      csr_rd(0, v); check32("R6 response full bit", v & 32'h18, 32'h10);
      pop_n(RESP_DEPTH);
   endtask

   task automatic t_irq;
      logic [31:0] v;
      csr_wr(1, 32'h10);
      push_desc(mk_desc(8'h50, 16'h0100, 32'h0000_4000), 1'b1);
      take("R10 completion irq desc", mk_desc(8'h50, 16'h0100, 32'h0000_4000));
      complete(8'h0, 1'b0);
      csr_rd(0, v); check32("R10 irq status on completion", v & 32'h200, 32'h200);
      check32("R10 irq pin", 32'(irq), 32'd1);
      csr_wr(0, 32'h200);
      csr_rd(0, v); check32("R11 irq cleared", v & 32'h200, 32'h0);
      check32("R10 irq pin cleared", 32'(irq), 32'd0);
      push_desc(mk_desc(8'h51, 16'h0101, 32'h0001_0000), 1'b1);
      take("R10 masked err desc", mk_desc(8'h51, 16'h0101, 32'h0001_0000));
      complete(8'h02, 1'b0);
      csr_rd(0, v); check32("R10 unmasked error no irq", v & 32'h280, 32'h0);
      push_desc(mk_desc(8'h52, 16'h0102, 32'h0001_0000), 1'b1);
      take("R10 err desc", mk_desc(8'h52, 16'h0102, 32'h0001_0000));
      complete(8'h01, 1'b0);
      csr_rd(0, v); check32("R10 masked error irq", v & 32'h200, 32'h200);
      csr_wr(0, 32'h200);
      csr_wr(1, 32'h00);
      push_desc(mk_desc(8'h53, 16'h0103, 32'h0000_4000), 1'b1);
      take("R10 gated desc", mk_desc(8'h53, 16'h0103, 32'h0000_4000));
      complete(8'h0, 1'b0);
      csr_rd(0, v); check32("R10 status set with enable off", v & 32'h200, 32'h200);
      check32("R10 pin gated by enable", 32'(irq), 32'd0);
      csr_wr(0, 32'h200);
      pop_n(4);
   endtask

   task automatic t_halt;
      logic [31:0] v;
      csr_wr(1, 32'h04);
      push_desc(mk_desc(8'h60, 16'h0200, 32'h0), 1'b1);
      push_desc(mk_desc(8'h61, 16'h0201, 32'h0), 1'b1);
      take("R9 first", mk_desc(8'h60, 16'h0200, 32'h0));
      complete(8'h01, 1'b0);
      csr_rd(0, v); check32("R9 error halt bits", v & 32'h1A1, 32'h0A0);
      repeat (5) begin
         @(negedge clk);
         check32("R9 halted no issue", 32'(issue_valid), 32'd0);
      end
      csr_wr(0, 32'h000);
      csr_rd(0, v); check32("R11 zero write keeps sticky", v & 32'h080, 32'h080);
      csr_wr(0, 32'h07F);
      csr_rd(0, v); check32("R11 other bits no effect", v & 32'h0A0, 32'h0A0);
      csr_wr(0, 32'h080);
      csr_rd(0, v); check32("R11 sticky cleared", v & 32'h080, 32'h0);
      take("R9 resumes", mk_desc(8'h61, 16'h0201, 32'h0));
      complete(8'h0, 1'b0);
      csr_rd(0, v); check32("R9 clean completion no halt", v & 32'h180, 32'h0);
      csr_wr(1, 32'h08);
      push_desc(mk_desc(8'h62, 16'h0202, 32'h0000_8000), 1'b1);
      take("R9 early desc", mk_desc(8'h62, 16'h0202, 32'h0000_8000));
      push_desc(mk_desc(8'h63, 16'h0203, 32'h0), 1'b1);
      complete(8'h0, 1'b1);
      csr_rd(0, v); check32("R9 early halt and R10 early irq", v & 32'h3A0, 32'h320);
      repeat (3) begin
         @(negedge clk);
         check32("R9 early halt no issue", 32'(issue_valid), 32'd0);
      end
      csr_wr(0, 32'h300);
      take("R9 resumes after early", mk_desc(8'h63, 16'h0203, 32'h0));
      complete(8'h0, 1'b0);
      pop_n(4);
   endtask

   task automatic t_reset_cmd;
      logic [31:0] v;
      csr_wr(1, 32'h10);
      push_desc(mk_desc(8'h70, 16'h0300, 32'h0000_4000), 1'b1);
      take("R12 setup", mk_desc(8'h70, 16'h0300, 32'h0000_4000));
      complete(8'h0, 1'b0);
      csr_wr(1, 32'h11);
      push_desc(mk_desc(8'h71, 16'h0301, 32'h0), 1'b1);
      push_desc(mk_desc(8'h72, 16'h0302, 32'h0), 1'b1);
      check32("R12 irq before reset", 32'(irq), 32'd1);
      csr_wr(1, 32'h03);
      csr_rd(0, v); check32("R12 resetting shown", v & 32'h40, 32'h40);
      csr_rd(1, v); check32("R12 control during reset", v, 32'h03);
      repeat (RST_CYCLES - 1) @(negedge clk);
      csr_rd(0, v); check32("R12 resetting last cycle", v & 32'h40, 32'h40);
      check32("R12 no issue during reset", 32'(issue_valid), 32'd0);
      @(negedge clk);
      csr_rd(0, v); check32("R12 status after reset phase", v, 32'h0000_000A);
      csr_rd(1, v); check32("R12 control cleared", v, 32'h0);
      csr_rd(2, v); check32("R12 fifo flushed", v, 32'h0);
      csr_rd(3, v); check32("R12 responses flushed", v, 32'h0);
      csr_rd(4, v); check32("R12 sequence cleared", v, 32'h0);
      check32("R12 irq cleared", 32'(irq), 32'd0);
      repeat (3) begin
         @(negedge clk);
         check32("R12 nothing left to issue", 32'(issue_valid), 32'd0);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         vectors++;
         errors++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset_state();
      t_staging();
      t_order();
      t_overflow();
      t_irq();
      t_halt();
      t_reset_cmd();
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end
endmodule